// File: doc/BRIEF.md
# Nested Interrupt Priority Resolver

This block keeps the per-vector bookkeeping of a small nested vectored interrupt controller and decides, every cycle, which vector should interrupt the processor next. Each vector carries an enable flag, a pending flag, an active flag and an 8-bit priority. External lines carry an additional sampled level. Vector 0 is never used. Vectors 1 to 15 are internal exceptions. External line `n` drives vector `16+n`.

The resolver picks the enabled, pending vector with the numerically smallest priority and forms the group priority of the active vectors using a programmable split point. It raises a registered request when the pending choice would preempt the running handler. Separately, it reports whether the choice may be taken once the CPU masking state (fault mask, primask, base priority) is applied. The CPU acknowledges and completes handlers through strobes. Software-style configuration operations enable, disable, prioritise, pend and un-pend vectors. Raising a synchronous fault that cannot run is escalated to HardFault, or to a lockup flag when HardFault itself is blocked.

Vector numbers used: 1 reset, 2 NMI, 3 HardFault, 4 MemManage, 5 BusFault, 6 UsageFault, 11 SVC, 12 Debug, 14 PendSV, 15 SysTick. Configuration opcodes on `cfg_op_i`: 0 none, 1 enable, 2 disable, 3 set priority, 4 set pending, 5 clear pending.

Top module: `nip_core`

## Requirements
- R1: After reset, `irq_req_o`, `pend_vec_o`, `exc_num_o`, `take_ok_o`, `hf_forced_o` and `lockup_o` are all zero.
- R2: `pend_vec_o` names the enabled, pending vector with the smallest priority; on equal priority the lower vector number wins; a pending but disabled vector is never chosen; with none eligible it reads 0.
- R3: NMI and HardFault have fixed priorities -2 and -1 (reset -3), so they beat every programmable priority; set-priority operations aimed at vectors 1 to 3 are ignored.
- R4: `irq_req_o` is a registered output, set one cycle after the state that makes the chosen pending priority strictly lower than the active group priority (256 when nothing is active); the CPU masking inputs do not affect it.
- R5: The active group priority is the smallest active priority ANDed with all-ones shifted left by `prio_group_i`+1.
- R6: `take_ok_o` is high when the execution priority exceeds the chosen pending priority (256 when none is chosen). The execution priority is -1 under fault mask, else 0 under primask, else the base priority masked to its group when nonzero, else 256. That value is then lowered to the active group priority if the latter is smaller.
- R7: An acknowledge with a vector chosen clears its pending flag, sets its active flag and reports it on `exc_num_o` from the next cycle; an acknowledge with nothing chosen changes nothing.
- R8: A rising edge on an external line pends its vector; a line held high does not pend again by itself.
- R9: Completion clears the vector's active flag; completing an external vector whose line is still high pends it again.
- R10: Pending a vector from 3 to 13 while it is disabled or its priority is not below the execution priority pends HardFault instead and sets `hf_forced_o`, which stays set until reset.
- R11: When such an escalation finds HardFault's priority (-1) not below the execution priority, nothing is pended and `lockup_o` is set and stays set until reset.
- R12: At reset NMI, HardFault, SVC, Debug, PendSV and SysTick are enabled; MemManage, BusFault, UsageFault and all external vectors are disabled; enable and disable operations act only on vectors 4 and above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines_i | input | NUM_EXT | External interrupt lines |
| fault_mask_i | input | 1 | CPU fault mask state |
| pri_mask_i | input | 1 | CPU primask state |
| base_prio_i | input | 8 | CPU base priority (0 = off) |
| prio_group_i | input | 3 | Group/subpriority split point |
| cfg_op_i | input | 3 | Configuration opcode |
| cfg_vec_i | input | VW | Vector targeted by the opcode |
| cfg_prio_i | input | 8 | Priority for the set-priority opcode |
| ack_i | input | 1 | CPU acknowledge strobe |
| cmpl_i | input | 1 | CPU completion strobe |
| cmpl_vec_i | input | VW | Vector being completed |
| irq_req_o | output | 1 | Registered preemption request |
| pend_vec_o | output | VW | Chosen pending vector (0 = none) |
| take_ok_o | output | 1 | Chosen vector may be taken under masking |
| exc_num_o | output | VW | Last acknowledged vector |
| hf_forced_o | output | 1 | Escalation to HardFault has occurred |
| lockup_o | output | 1 | HardFault could not be taken |

## Verification
The bound checker watches, every cycle, the stickiness of the escalation and lockup flags, that the reset vector is never chosen, that a request or a take permission never appears without a chosen vector, and that an acknowledge reports the vector chosen in the cycle before. Which vector wins under specific priority mixes, how the group split changes the request, the arithmetic of the execution priority under each mask, line edge and re-pend behaviour, and the escalation outcomes depend on programmed values and are shown by the bench's directed scenarios.

// File: rtl/nip_pkg.sv
package nip_pkg;

    localparam int PW          = 10;   // signed priority width (-3 .. 256)
    localparam int NO_EXC      = 256;
    localparam int VEC_RESET   = 1;
    localparam int VEC_NMI     = 2;
    localparam int VEC_HARD    = 3;
    localparam int VEC_MEM     = 4;
    localparam int VEC_BUS     = 5;
    localparam int VEC_USAGE   = 6;
    localparam int VEC_SVC     = 11;
    localparam int VEC_DEBUG   = 12;
    localparam int VEC_PENDSV  = 14;
    localparam int VEC_SYSTICK = 15;
    localparam int FIRST_EXT   = 16;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_ENABLE  = 3'd1,
        OP_DISABLE = 3'd2,
        OP_PRIO    = 3'd3,
        OP_SETPEND = 3'd4,
        OP_CLRPEND = 3'd5
    } nip_op_e;

endpackage

// File: rtl/nip_select.sv
module nip_select #(
    parameter int NV = 32,
    parameter int VW = 5,
    parameter int PW = 10
) (
    input  logic [NV-1:0]         en_i,
    input  logic [NV-1:0]         pend_i,
    input  logic [NV-1:0]         act_i,
    input  logic [NV-1:0][PW-1:0] prio_i,
    output logic [VW-1:0]         pend_vec_o,
    output logic [PW-1:0]         pend_prio_o,
    output logic [PW-1:0]         act_min_o
);
    localparam logic signed [PW-1:0] NONE = PW'(nip_pkg::NO_EXC);

    logic signed [PW-1:0] best_p;
    logic signed [PW-1:0] amin;
    logic [VW-1:0]        best_v;

    // Strict "less than" keeps the lowest vector number on ties.
    always_comb begin
        best_p = NONE;
        amin   = NONE;
        best_v = '0;
        for (int v = 1; v < NV; v++) begin
            if (en_i[v] && pend_i[v] && ($signed(prio_i[v]) < best_p)) begin
                best_p = $signed(prio_i[v]);
                best_v = VW'(v);
            end
            if (act_i[v] && ($signed(prio_i[v]) < amin)) begin
                amin = $signed(prio_i[v]);
            end
        end
    end

    assign pend_vec_o  = best_v;
    assign pend_prio_o = best_p;
    assign act_min_o   = amin;

endmodule

// File: rtl/nip_exec.sv
module nip_exec #(
    parameter int PW = 10
) (
    input  logic [PW-1:0] act_min_i,
    input  logic [PW-1:0] pend_prio_i,
    input  logic          fault_mask_i,
    input  logic          pri_mask_i,
    input  logic [7:0]    base_prio_i,
    input  logic [2:0]    prio_group_i,
    output logic [PW-1:0] act_grp_o,
    output logic [PW-1:0] exec_prio_o,
    output logic          take_ok_o
);
    logic [PW-1:0]        grp_mask;
    logic [PW-1:0]        base_grp;
    logic signed [PW-1:0] running;
    logic signed [PW-1:0] act_grp;

    assign grp_mask = {PW{1'b1}} << ({1'b0, prio_group_i} + 4'd1);
    assign base_grp = {{(PW-8){1'b0}}, base_prio_i} & grp_mask;
    assign act_grp  = $signed(act_min_i & grp_mask);

    always_comb begin
        if (fault_mask_i) begin
            running = -PW'(1);
        end else if (pri_mask_i) begin
            running = '0;
        end else if (base_prio_i != 8'd0) begin
            running = $signed(base_grp);
        end else begin
            running = PW'(nip_pkg::NO_EXC);
        end
    end

    assign act_grp_o   = act_grp;
    assign exec_prio_o = (act_grp < running) ? act_grp : running;
    assign take_ok_o   = $signed(exec_prio_o) > $signed(pend_prio_i);

endmodule

// File: rtl/nip_core.sv
module nip_core #(
    parameter int NUM_EXT = 16,
    parameter int NV      = nip_pkg::FIRST_EXT + NUM_EXT,
    parameter int VW      = $clog2(NV)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EXT-1:0] irq_lines_i,
    input  logic               fault_mask_i,
    input  logic               pri_mask_i,
    input  logic [7:0]         base_prio_i,
    input  logic [2:0]         prio_group_i,
    input  logic [2:0]         cfg_op_i,
    input  logic [VW-1:0]      cfg_vec_i,
    input  logic [7:0]         cfg_prio_i,
    input  logic               ack_i,
    input  logic               cmpl_i,
    input  logic [VW-1:0]      cmpl_vec_i,
    output logic               irq_req_o,
    output logic [VW-1:0]      pend_vec_o,
    output logic               take_ok_o,
    output logic [VW-1:0]      exc_num_o,
    output logic               hf_forced_o,
    output logic               lockup_o
);
    import nip_pkg::*;

    typedef struct packed {
        logic [NV-1:0]        en;
        logic [NV-1:0]        pend;
        logic [NV-1:0]        act;
        logic [NUM_EXT-1:0]   lvl;
        logic [NV-1:0][7:0]   prio;
        logic [VW-1:0]        exc;
        logic                 forced;
        logic                 lockup;
        logic                 irq;
    } nip_state_t;

    localparam logic [NV-1:0] EN_RST = NV'((1 << VEC_NMI) | (1 << VEC_HARD) |
                                           (1 << VEC_SVC) | (1 << VEC_DEBUG) |
                                           (1 << VEC_PENDSV) | (1 << VEC_SYSTICK));

    nip_state_t q, d;

    logic [NV-1:0][PW-1:0] eff_prio;
    logic [VW-1:0]         pick_vec;
    logic [PW-1:0]         pick_prio;
    logic [PW-1:0]         act_min;
    logic [PW-1:0]         act_grp;
    logic [PW-1:0]         exec_prio;
    logic                  take_ok;

    // Fixed priorities for reset, NMI and HardFault; programmable elsewhere.
    for (genvar v = 0; v < NV; v++) begin : g_prio
        if (v == VEC_RESET) begin : g_rst
            assign eff_prio[v] = -PW'(3);
        end else if (v == VEC_NMI) begin : g_nmi
            assign eff_prio[v] = -PW'(2);
        end else if (v == VEC_HARD) begin : g_hard
            assign eff_prio[v] = -PW'(1);
        end else if (v == 0) begin : g_zero
            assign eff_prio[v] = PW'(NO_EXC);
        end else begin : g_prog
            assign eff_prio[v] = {{(PW-8){1'b0}}, q.prio[v]};
        end
    end

    nip_select #(.NV(NV), .VW(VW), .PW(PW)) u_select (
        .en_i        (q.en),
        .pend_i      (q.pend),
        .act_i       (q.act),
        .prio_i      (eff_prio),
        .pend_vec_o  (pick_vec),
        .pend_prio_o (pick_prio),
        .act_min_o   (act_min)
    );

    nip_exec #(.PW(PW)) u_exec (
        .act_min_i    (act_min),
        .pend_prio_i  (pick_prio),
        .fault_mask_i (fault_mask_i),
        .pri_mask_i   (pri_mask_i),
        .base_prio_i  (base_prio_i),
        .prio_group_i (prio_group_i),
        .act_grp_o    (act_grp),
        .exec_prio_o  (exec_prio),
        .take_ok_o    (take_ok)
    );

    always_comb begin
        int unsigned cv;
        int unsigned kv;
        logic        esc;
        d   = q;
        cv  = int'(cfg_vec_i);
        kv  = int'(cmpl_vec_i);
        esc = 1'b0;

        // External lines: rising edge pends the matching vector.
        d.lvl = irq_lines_i;
        for (int n = 0; n < NUM_EXT; n++) begin
            if (irq_lines_i[n] && !q.lvl[n]) begin
                d.pend[FIRST_EXT + n] = 1'b1;
            end
        end

        // Configuration operation.
        unique case (nip_op_e'(cfg_op_i))
            OP_ENABLE: begin
                if (cv >= VEC_MEM && cv < NV) d.en[cv] = 1'b1;
            end
            OP_DISABLE: begin
                if (cv >= VEC_MEM && cv < NV) d.en[cv] = 1'b0;
            end
            OP_PRIO: begin
                if (cv >= VEC_MEM && cv < NV) d.prio[cv] = cfg_prio_i;
            end
            OP_SETPEND: begin
                if (cv >= VEC_NMI && cv < NV) begin
                    if (cv >= VEC_HARD && cv < VEC_PENDSV) begin
                        esc = ($signed(eff_prio[cv]) >= $signed(exec_prio)) || !q.en[cv];
                    end
                    if (!esc) begin
                        d.pend[cv] = 1'b1;
                    end else if ($signed(eff_prio[VEC_HARD]) >= $signed(exec_prio)) begin
                        d.lockup = 1'b1;
                    end else begin
                        d.pend[VEC_HARD] = 1'b1;
                        d.forced         = 1'b1;
                    end
                end
            end
            OP_CLRPEND: begin
                if (cv >= VEC_NMI && cv < NV) d.pend[cv] = 1'b0;
            end
            default: ;
        endcase

        // Completion: leave the handler, re-pend a still-high line.
        if (cmpl_i && kv >= VEC_NMI && kv < NV) begin
            d.act[kv] = 1'b0;
            if (kv >= FIRST_EXT && irq_lines_i[kv - FIRST_EXT]) begin
                d.pend[kv] = 1'b1;
            end
        end

        // Acknowledge: move the chosen vector from pending to active.
        if (ack_i && pick_vec != '0) begin
            d.pend[pick_vec] = 1'b0;
            d.act[pick_vec]  = 1'b1;
            d.exc            = pick_vec;
        end

        // Preemption request, ignoring CPU masking state.
        d.irq = $signed(pick_prio) < $signed(act_grp);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q        <= '0;
            q.en     <= EN_RST;
        end else begin
            q <= d;
        end
    end

    assign irq_req_o   = q.irq;
    assign pend_vec_o  = pick_vec;
    assign take_ok_o   = take_ok;
    assign exc_num_o   = q.exc;
    assign hf_forced_o = q.forced;
    assign lockup_o    = q.lockup;

endmodule

// File: rtl/nip_chk.sv
module nip_chk #(
    parameter int VW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ack_i,
    input logic          irq_req_o,
    input logic [VW-1:0] pend_vec_o,
    input logic          take_ok_o,
    input logic [VW-1:0] exc_num_o,
    input logic          hf_forced_o,
    input logic          lockup_o
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> (!irq_req_o && !lockup_o && !hf_forced_o));

    // R2
    no_reset_pick_chk: assert property (@(posedge clk) disable iff (!rst_n) pend_vec_o != VW'(1));

    // R4
    req_needs_pick_chk: assert property (@(posedge clk) disable iff (!rst_n) irq_req_o |-> $past(pend_vec_o) != '0);

    // R6
    take_needs_pick_chk: assert property (@(posedge clk) disable iff (!rst_n) take_ok_o |-> pend_vec_o != '0);

    // R7
    ack_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && pend_vec_o != '0) |=> exc_num_o == $past(pend_vec_o));

    // R10
    forced_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) hf_forced_o |=> hf_forced_o);

    // R11
    lockup_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) lockup_o |=> lockup_o);

endmodule

bind nip_core nip_chk #(.VW(VW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack_i       (ack_i),
    .irq_req_o   (irq_req_o),
    .pend_vec_o  (pend_vec_o),
    .take_ok_o   (take_ok_o),
    .exc_num_o   (exc_num_o),
    .hf_forced_o (hf_forced_o),
    .lockup_o    (lockup_o)
);

// File: tb/nip_core_bench.sv
module nip_core_bench;
    localparam int NUM_EXT = 16;
    localparam int VW      = 5;

    localparam logic [2:0] ENA = 3'd1, DIS = 3'd2, PRI = 3'd3, SETP = 3'd4, CLRP = 3'd5;

    logic               clk = 1'b0;
    logic               rst_n;
    logic [NUM_EXT-1:0] irq_lines;
    logic               fault_mask, pri_mask;
    logic [7:0]         base_prio;
    logic [2:0]         prio_group;
    logic [2:0]         cfg_op;
    logic [VW-1:0]      cfg_vec;
    logic [7:0]         cfg_prio;
    logic               ack, cmpl;
    logic [VW-1:0]      cmpl_vec;
    logic               irq_req, take_ok, hf_forced, lockup;
    logic [VW-1:0]      pend_vec, exc_num;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    nip_core #(.NUM_EXT(NUM_EXT)) u_nip_core (
        .clk(clk), .rst_n(rst_n), .irq_lines_i(irq_lines),
        .fault_mask_i(fault_mask), .pri_mask_i(pri_mask),
        .base_prio_i(base_prio), .prio_group_i(prio_group),
        .cfg_op_i(cfg_op), .cfg_vec_i(cfg_vec), .cfg_prio_i(cfg_prio),
        .ack_i(ack), .cmpl_i(cmpl), .cmpl_vec_i(cmpl_vec),
        .irq_req_o(irq_req), .pend_vec_o(pend_vec), .take_ok_o(take_ok),
        .exc_num_o(exc_num), .hf_forced_o(hf_forced), .lockup_o(lockup)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; irq_lines = '0; fault_mask = 0; pri_mask = 0;
        base_prio = 0; prio_group = 0; cfg_op = 0; cfg_vec = 0; cfg_prio = 0;
        ack = 0; cmpl = 0; cmpl_vec = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    // Drive an opcode for one cycle, then let the registered request settle.
    task automatic op(input logic [2:0] o, input int v, input int p);
        @(negedge clk);
        cfg_op = o; cfg_vec = VW'(v); cfg_prio = 8'(p);
        @(negedge clk);
        cfg_op = 0;
        @(negedge clk);
    endtask

    task automatic do_ack();
        @(negedge clk); ack = 1;
        @(negedge clk); ack = 0;
        @(negedge clk);
    endtask

    task automatic do_cmpl(input int v);
        @(negedge clk); cmpl = 1; cmpl_vec = VW'(v);
        @(negedge clk); cmpl = 0;
        @(negedge clk);
    endtask

    task automatic set_line(input int n, input logic val);
        @(negedge clk); irq_lines[n] = val;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 irq_req", irq_req, 0);
        chk("R1 pend_vec", pend_vec, 0);
        chk("R1 exc_num", exc_num, 0);
        chk("R1 take_ok", take_ok, 0);
        chk("R1 hf_forced", hf_forced, 0);
        chk("R1 lockup", lockup, 0);
    endtask

    task automatic t_select();
        do_reset();
        op(ENA, 16, 0); op(ENA, 17, 0); op(ENA, 18, 0);
        op(PRI, 16, 'h40); op(PRI, 17, 'h20); op(PRI, 18, 'h20);
        op(SETP, 16, 0);
        chk("R2 single pending", pend_vec, 16);
        chk("R4 request vs idle", irq_req, 1);
        op(SETP, 18, 0);
        chk("R2 smaller priority", pend_vec, 18);
        op(SETP, 17, 0);
        chk("R2 tie lowest number", pend_vec, 17);
        op(DIS, 17, 0);
        chk("R2 disabled skipped", pend_vec, 18);
        op(SETP, 19, 0);
        chk("R2 disabled pending ignored", pend_vec, 18);
    endtask

    task automatic t_fixed();
        do_reset();
        op(PRI, 3, 'hFF);
        op(SETP, 11, 0);
        chk("R12 SVC enabled", pend_vec, 11);
        op(SETP, 3, 0);
        chk("R3 HardFault beats prio 0", pend_vec, 3);
        op(SETP, 2, 0);
        chk("R3 NMI beats HardFault", pend_vec, 2);
        @(negedge clk); pri_mask = 1; @(negedge clk);
        chk("R6 primask passes NMI", take_ok, 1);
        op(CLRP, 2, 0);
        chk("R3 prio write to HardFault ignored", pend_vec, 3);
        chk("R6 primask passes HardFault", take_ok, 1);
        op(CLRP, 3, 0);
        chk("R6 primask blocks prio 0", take_ok, 0);
    endtask

    task automatic t_group();
        do_reset();
        op(ENA, 16, 0); op(ENA, 17, 0);
        op(PRI, 16, 'h35); op(PRI, 17, 'h31);
        @(negedge clk); prio_group = 3;
        op(SETP, 16, 0);
        do_ack();
        chk("R7 exc_num after ack", exc_num, 16);
        chk("R7 pending cleared", pend_vec, 0);
        op(SETP, 17, 0);
        chk("R5 same group no request", irq_req, 0);
        @(negedge clk); prio_group = 0;
        repeat (2) @(negedge clk);
        chk("R5 finer split requests", irq_req, 1);
    endtask

    task automatic t_exec();
        do_reset();
        op(ENA, 16, 0); op(PRI, 16, 'h20); op(SETP, 16, 0);
        chk("R6 unmasked take", take_ok, 1);
        @(negedge clk); pri_mask = 1; @(negedge clk);
        chk("R6 primask blocks", take_ok, 0);
        chk("R4 request ignores masks", irq_req, 1);
        @(negedge clk); pri_mask = 0; base_prio = 'h21; @(negedge clk);
        chk("R6 base masked to group", take_ok, 0);
        @(negedge clk); base_prio = 'h22; @(negedge clk);
        chk("R6 base above pending", take_ok, 1);
        @(negedge clk); fault_mask = 1; @(negedge clk);
        chk("R6 fault mask blocks", take_ok, 0);
    endtask

    task automatic t_lines();
        do_reset();
        op(ENA, 16, 0); op(PRI, 16, 'h10);
        op(ENA, 17, 0); op(PRI, 17, 'h50);
        set_line(0, 1);
        chk("R8 rising edge pends", pend_vec, 16);
        do_ack();
        chk("R7 ack reports vector", exc_num, 16);
        chk("R7 ack clears pending", pend_vec, 0);
        do_ack();
        chk("R7 empty ack ignored", exc_num, 16);
        repeat (2) @(negedge clk);
        chk("R8 held level no re-pend", pend_vec, 0);
        do_cmpl(16);
        chk("R9 re-pend on completion", pend_vec, 16);
        do_ack();
        set_line(0, 0);
        op(SETP, 17, 0);
        chk("R4 lower prio no preempt", irq_req, 0);
        do_cmpl(16);
        chk("R9 low line no re-pend", pend_vec, 17);
        chk("R9 completion clears active", irq_req, 1);
    endtask

    task automatic t_escal();
        do_reset();
        op(SETP, 4, 0);
        chk("R12 MemManage disabled escalates", pend_vec, 3);
        chk("R10 forced flag", hf_forced, 1);
        do_reset();
        op(ENA, 4, 0); op(PRI, 4, 'h40);
        op(SETP, 4, 0);
        chk("R10 enabled fault no escalation", pend_vec, 4);
        chk("R10 no forced flag", hf_forced, 0);
        op(CLRP, 4, 0);
        op(ENA, 16, 0); op(PRI, 16, 'h10); op(SETP, 16, 0);
        do_ack();
        op(SETP, 4, 0);
        chk("R10 priority escalation", pend_vec, 3);
        chk("R10 forced after priority", hf_forced, 1);
        op(SETP, 15, 0);
        chk("R12 SysTick enabled", pend_vec, 3);
    endtask

    task automatic t_lockup();
        do_reset();
        @(negedge clk); fault_mask = 1;
        op(SETP, 3, 0);
        chk("R11 lockup set", lockup, 1);
        chk("R11 nothing pended", pend_vec, 0);
        chk("R11 not forced", hf_forced, 0);
        do_reset();
        @(negedge clk); fault_mask = 1;
        op(SETP, 5, 0);
        chk("R11 lockup via BusFault", lockup, 1);
        op(SETP, 14, 0);
        chk("R12 PendSV enabled", pend_vec, 14);
        chk("R11 lockup holds", lockup, 1);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual running expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_select();
        t_fixed();
        t_group();
        t_exec();
        t_lines();
        t_escal();
        t_lockup();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule